// File: doc/BRIEF.md
# TLB Selective Invalidation Engine

This block holds a small translation buffer split into several arrays. It removes entries from that buffer on command. A command carries a 2-bit scope, an effective address, a search process ID, an indirect flag, a guest-state flag and a user-mode flag.

- The broadest scope clears every entry.
- A narrower scope clears the entries tagged with one process ID.
- The narrowest scope looks only at the ways of the set that the address selects, and clears an entry there when its page covers the address and every tag agrees.

Entries marked protected survive every scope. The engine visits one slot per clock and holds `busy` while it walks. It pulses `done` when the walk ends, and pulses a flush strobe for shadow translation state in the cycle after that.

Software loads entries through a write port and reads them back through a combinational read port. Slots are numbered `arr*SETS*WAYS + set*WAYS + way`. An array can be built shallower than the other arrays. A slot past an array's depth does not exist.

Top module: `tlb_sel_inval`

## Requirements
- R1: After reset, `busy`, `done`, `err_illegal`, `err_priv` and `shadow_flush` are low, and every slot reads as zero.
- R2: An entry is 48 bits wide, with fields from the top bit down:
  - bit 47: valid
  - bit 46: protect
  - bit 45: indirect
  - bit 44: guest space
  - bits 43:36: TID
  - bits 35:32: size code
  - bits 31:0: page address
  
  A write stores the entry at `ent_wr_sel`, and `ent_rd_data` shows the slot at `ent_rd_sel` in the same cycle.
- R3: With the default depths (array 0 has 16 slots, array 1 has 12), writes to slots 28 to 31 are ignored, those slots read zero, and walks skip them.
- R4: While `busy` is high, entry writes and new commands are ignored.
- R5: A command with `cmd_user`=1 raises `err_priv` for one cycle, starting the cycle after acceptance. This takes priority over the scope check. No walk starts and no entry changes.
- R6: Scope code 2 with `cmd_user`=0 raises `err_illegal` for one cycle, starting the cycle after acceptance. No walk starts and no entry changes.
- R7: Scope code 0 clears the valid bit of every unprotected entry in every array.
- R8: Scope code 1 clears the valid bit of every unprotected entry whose TID equals `cmd_pid`.
- R9: Scope code 3 clears an unprotected entry when all of these hold:
  - its TID equals `cmd_pid`;
  - its indirect bit equals `cmd_ind`;
  - its guest bit equals `cmd_gs`;
  - the address and the entry's page address agree under the mask `~((1024 << size) - 1)`.
- R10: Scope code 3 examines only slots `arr*16 + set*2 + way`, where `set` = `cmd_ea[14:12]`. Matching entries in other sets are kept.
- R11: A protected entry is never cleared by any scope.
- R12: `busy` rises the cycle after acceptance. It stays high for 32 cycles under scopes 0 and 1 and for 4 cycles under scope 3. `done` is high in the single cycle after the last busy cycle, and `shadow_flush` is high in the single cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_user | input | 1 | Issuer is in user mode |
| cmd_mode | input | 2 | Invalidation scope code |
| cmd_ea | input | 32 | Effective address |
| cmd_pid | input | 8 | Search process ID |
| cmd_ind | input | 1 | Requested indirect flag |
| cmd_gs | input | 1 | Requested guest-state flag |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_sel | input | 5 | Slot written |
| ent_wr_data | input | 48 | Entry written |
| ent_rd_sel | input | 5 | Slot read |
| ent_rd_data | output | 48 | Entry read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished pulse |
| err_illegal | output | 1 | Reserved scope pulse |
| err_priv | output | 1 | Privilege violation pulse |
| shadow_flush | output | 1 | Shadow translation flush strobe |

## Verification
A cursor that skips a slot or visits the wrong set leaves a valid bit set where it should be cleared, or clears one that should stay. The read port shows this as soon as `done` rises. A wrong walk length moves `done` away from its expected cycle, which is 33 or 5 cycles after the command edge. A bad latch of the command fields shows up as wrong entries after a single command. Every command is followed by a full read-back of all slots.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int EA_W    = 32;
    localparam int TID_W   = 8;
    localparam int TSZ_W   = 4;
    localparam int PAGE_LG = 10;   // smallest page is 1 KiB

    typedef enum logic [1:0] {
        INV_ALL  = 2'd0,
        INV_PID  = 2'd1,
        INV_RSVD = 2'd2,
        INV_PAGE = 2'd3
    } inv_mode_e;

    typedef struct packed {
        logic             valid;
        logic             prot;
        logic             ind;
        logic             gs;
        logic [TID_W-1:0] tid;
        logic [TSZ_W-1:0] tsize;
        logic [EA_W-1:0]  epn;
    } tlb_ent_t;

    localparam int ENT_W = $bits(tlb_ent_t);

    typedef struct packed {
        inv_mode_e        mode;
        logic [EA_W-1:0]  ea;
        logic [TID_W-1:0] pid;
        logic             ind;
        logic             gs;
    } inv_req_t;

    // Address bits above the page offset of a page with this size code.
    function automatic logic [EA_W-1:0] page_mask(logic [TSZ_W-1:0] tsz);
        logic [EA_W-1:0] bytes;
        bytes = EA_W'(1) << (PAGE_LG + int'(tsz));
        return ~(bytes - EA_W'(1));
    endfunction

endpackage

// File: rtl/tsi_match.sv
module tsi_match
    import tsi_pkg::*;
(
    input  tlb_ent_t ent,
    input  inv_req_t req,
    output logic     hit
);
    logic tags_eq;
    logic page_eq;

    always_comb begin
        tags_eq = (ent.tid == req.pid) && (ent.ind == req.ind) && (ent.gs == req.gs);
        page_eq = ((req.ea ^ ent.epn) & page_mask(ent.tsize)) == '0;
        case (req.mode)
            INV_ALL:  hit = !ent.prot;
            INV_PID:  hit = !ent.prot && (ent.tid == req.pid);
            INV_PAGE: hit = !ent.prot && tags_eq && page_eq;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsi_walker.sv
module tsi_walker
    import tsi_pkg::*;
#(
    parameter int N_ARR   = 2,
    parameter int SETS    = 8,
    parameter int WAYS    = 2,
    parameter int IDX_LSB = 12,
    parameter logic [N_ARR*8-1:0] DEPTHS = 16'h0C10,
    localparam int SLOTS  = SETS * WAYS,
    localparam int TOTAL  = N_ARR * SLOTS,
    localparam int SEL_W  = $clog2(TOTAL),
    localparam int SET_W  = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_user,
    input  inv_req_t         cmd_req,
    output logic             busy,
    output logic             done,
    output logic             err_illegal,
    output logic             err_priv,
    output logic             flush,
    output inv_req_t         req_q,
    output logic [SEL_W-1:0] visit_sel,
    output logic             visit_ok
);
    logic             busy_q, done_q, ill_q, priv_q, flush_q;
    logic [SEL_W-1:0] cnt_q;
    logic             last;
    int               arr_i, loc_i, set_i, span;

    function automatic int depth_of(int a);
        return int'(DEPTHS[a*8 +: 8]);
    endfunction

    always_comb begin
        set_i = int'(req_q.ea[IDX_LSB +: SET_W]);
        if (req_q.mode == INV_PAGE) begin
            span  = N_ARR * WAYS;
            arr_i = int'(cnt_q) / WAYS;
            loc_i = set_i * WAYS + int'(cnt_q) % WAYS;
        end else begin
            span  = TOTAL;
            arr_i = int'(cnt_q) / SLOTS;
            loc_i = int'(cnt_q) % SLOTS;
        end
        visit_sel = SEL_W'(arr_i * SLOTS + loc_i);
        visit_ok  = busy_q && (loc_i < depth_of(arr_i));
        last      = (int'(cnt_q) == span - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            priv_q  <= 1'b0;
            flush_q <= 1'b0;
            cnt_q   <= '0;
            req_q   <= '0;
        end else begin
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            priv_q  <= 1'b0;
            flush_q <= done_q;
            if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (cmd_valid) begin
                if (cmd_user) begin
                    priv_q <= 1'b1;
                end else if (cmd_req.mode == INV_RSVD) begin
                    ill_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    req_q  <= cmd_req;
                end
            end
        end
    end

    assign busy        = busy_q;
    assign done        = done_q;
    assign err_illegal = ill_q;
    assign err_priv    = priv_q;
    assign flush       = flush_q;
endmodule

// File: rtl/tsi_store.sv
module tsi_store
    import tsi_pkg::*;
#(
    parameter int N_ARR = 2,
    parameter int SLOTS = 16,
    parameter logic [N_ARR*8-1:0] DEPTHS = 16'h0C10,
    localparam int TOTAL = N_ARR * SLOTS,
    localparam int SEL_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  tlb_ent_t         wr_ent,
    input  logic             clr_en,
    input  logic [SEL_W-1:0] clr_sel,
    input  logic [SEL_W-1:0] rd_sel,
    output tlb_ent_t         rd_ent,
    input  logic [SEL_W-1:0] chk_sel,
    output tlb_ent_t         chk_ent
);
    tlb_ent_t slots [TOTAL];

    for (genvar i = 0; i < TOTAL; i++) begin : g_slot
        localparam int ARR = i / SLOTS;
        localparam int LOC = i % SLOTS;
        localparam int DEP = int'(DEPTHS[ARR*8 +: 8]);
        if (LOC < DEP) begin : g_live
            tlb_ent_t ent_q;
            always_ff @(posedge clk) begin
                if (rst)
                    ent_q <= '0;
                else if (wr_en && wr_sel == SEL_W'(i))
                    ent_q <= wr_ent;
                else if (clr_en && clr_sel == SEL_W'(i))
                    ent_q.valid <= 1'b0;
            end
            assign slots[i] = ent_q;
        end else begin : g_hole
            assign slots[i] = '0;
        end
    end

    assign rd_ent  = slots[rd_sel];
    assign chk_ent = slots[chk_sel];
endmodule

// File: rtl/tlb_sel_inval.sv
module tlb_sel_inval
    import tsi_pkg::*;
#(
    parameter int N_ARR   = 2,
    parameter int SETS    = 8,
    parameter int WAYS    = 2,
    parameter int IDX_LSB = 12,
    parameter logic [N_ARR*8-1:0] DEPTHS = 16'h0C10,
    localparam int SEL_W  = $clog2(N_ARR * SETS * WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_user,
    input  logic [1:0]       cmd_mode,
    input  logic [EA_W-1:0]  cmd_ea,
    input  logic [TID_W-1:0] cmd_pid,
    input  logic             cmd_ind,
    input  logic             cmd_gs,
    input  logic             ent_wr_en,
    input  logic [SEL_W-1:0] ent_wr_sel,
    input  logic [ENT_W-1:0] ent_wr_data,
    input  logic [SEL_W-1:0] ent_rd_sel,
    output logic [ENT_W-1:0] ent_rd_data,
    output logic             busy,
    output logic             done,
    output logic             err_illegal,
    output logic             err_priv,
    output logic             shadow_flush
);
    inv_req_t         cmd_req, req_q;
    logic [SEL_W-1:0] visit_sel;
    logic             visit_ok, hit;
    tlb_ent_t         rd_ent, chk_ent;

    assign cmd_req = '{mode: inv_mode_e'(cmd_mode), ea: cmd_ea, pid: cmd_pid,
                       ind: cmd_ind, gs: cmd_gs};

    tsi_walker #(
        .N_ARR(N_ARR), .SETS(SETS), .WAYS(WAYS),
        .IDX_LSB(IDX_LSB), .DEPTHS(DEPTHS)
    ) u_walk (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_user(cmd_user),
        .cmd_req(cmd_req), .busy(busy), .done(done), .err_illegal(err_illegal),
        .err_priv(err_priv), .flush(shadow_flush), .req_q(req_q),
        .visit_sel(visit_sel), .visit_ok(visit_ok)
    );

    tsi_store #(
        .N_ARR(N_ARR), .SLOTS(SETS * WAYS), .DEPTHS(DEPTHS)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr_en(ent_wr_en && !busy), .wr_sel(ent_wr_sel), .wr_ent(tlb_ent_t'(ent_wr_data)),
        .clr_en(visit_ok && hit), .clr_sel(visit_sel),
        .rd_sel(ent_rd_sel), .rd_ent(rd_ent),
        .chk_sel(visit_sel), .chk_ent(chk_ent)
    );

    tsi_match u_match (.ent(chk_ent), .req(req_q), .hit(hit));

    assign ent_rd_data = rd_ent;
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
    parameter int TOTAL = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_user,
    input logic [1:0] cmd_mode,
    input logic       ent_wr_en,
    input logic [4:0] ent_rd_sel,
    input logic       rd_valid,
    input logic       rd_prot,
    input logic       busy,
    input logic       done,
    input logic       err_illegal,
    input logic       err_priv,
    input logic       shadow_flush
);
    localparam int RUN_W = $clog2(TOTAL) + 1;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    p_done_ends_walk_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    p_flush_follows_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> shadow_flush);
    p_flush_cause_r12: assert property (@(posedge clk) disable iff (rst)
        shadow_flush |-> $past(done));
    p_one_event_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err_illegal, err_priv}));
    p_busy_bound_r12: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RUN_W'(TOTAL)));
    p_priv_cause_r5: assert property (@(posedge clk) disable iff (rst)
        err_priv |-> $past(cmd_valid && cmd_user && !busy));
    p_illegal_cause_r6: assert property (@(posedge clk) disable iff (rst)
        err_illegal |-> $past(cmd_valid && !cmd_user && cmd_mode == 2'd2 && !busy));
    p_err_no_walk_r6: assert property (@(posedge clk) disable iff (rst)
        (err_illegal || err_priv) |-> !busy);
    p_busy_cmd_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> !(err_illegal || err_priv));
    p_prot_kept_r11: assert property (@(posedge clk) disable iff (rst)
        ($stable(ent_rd_sel) && !$past(ent_wr_en) && $past(rd_valid) && $past(rd_prot))
        |-> rd_valid);
endmodule

bind tlb_sel_inval tsi_checker #(.TOTAL(N_ARR * SETS * WAYS)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_user(cmd_user),
    .cmd_mode(cmd_mode), .ent_wr_en(ent_wr_en), .ent_rd_sel(ent_rd_sel),
    .rd_valid(ent_rd_data[tsi_pkg::ENT_W-1]), .rd_prot(ent_rd_data[tsi_pkg::ENT_W-2]),
    .busy(busy), .done(done), .err_illegal(err_illegal), .err_priv(err_priv),
    .shadow_flush(shadow_flush)
);

// File: tb/sim_tlb_sel_inval.sv
module sim_tlb_sel_inval;
    localparam int TOTAL = 32;
    localparam int SLOTS = 16;
    localparam int N_ARR = 2;
    localparam int WAYS  = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        cmd_valid = 0, cmd_user = 0, cmd_ind = 0, cmd_gs = 0;
    logic [1:0]  cmd_mode = 0;
    logic [31:0] cmd_ea = 0;
    logic [7:0]  cmd_pid = 0;
    logic        ent_wr_en = 0;
    logic [4:0]  ent_wr_sel = 0, ent_rd_sel = 0;
    logic [47:0] ent_wr_data = 0;
    logic [47:0] ent_rd_data;
    logic        busy, done, err_illegal, err_priv, shadow_flush;

    tlb_sel_inval u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_user(cmd_user),
        .cmd_mode(cmd_mode), .cmd_ea(cmd_ea), .cmd_pid(cmd_pid), .cmd_ind(cmd_ind),
        .cmd_gs(cmd_gs), .ent_wr_en(ent_wr_en), .ent_wr_sel(ent_wr_sel),
        .ent_wr_data(ent_wr_data), .ent_rd_sel(ent_rd_sel), .ent_rd_data(ent_rd_data),
        .busy(busy), .done(done), .err_illegal(err_illegal), .err_priv(err_priv),
        .shadow_flush(shadow_flush)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    logic [47:0] mdl [TOTAL];

    typedef struct { int kind; int lat; int at; string req; } exp_t;
    exp_t sbq[$];
    bit prev_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exists(int sel);
        int dep = (sel / SLOTS == 0) ? 16 : 12;
        return (sel % SLOTS) < dep;
    endfunction

    function automatic logic [47:0] mk(bit v, bit p, bit ind, bit gs, logic [7:0] tid,
                                       logic [3:0] tsz, logic [31:0] epn);
        return {v, p, ind, gs, tid, tsz, epn};
    endfunction

    // Model of the requirements: R7, R8, R9, R10, R11
    function automatic void model_apply(logic [1:0] mode, logic [31:0] ea, logic [7:0] pid,
                                        bit ind, bit gs);
        for (int s = 0; s < TOTAL; s++) begin
            logic [47:0] e = mdl[s];
            bit take = 0;
            if (!exists(s) || e[46]) continue;
            if (mode == 2'd0) take = 1;
            else if (mode == 2'd1) take = (e[43:36] == pid);
            else if (mode == 2'd3) begin
                logic [31:0] msk = ~((32'd1024 << e[35:32]) - 32'd1);
                int set = int'(ea[14:12]);
                bit in_set = ((s % SLOTS) / WAYS) == set;
                take = in_set && e[43:36] == pid && e[45] == ind && e[44] == gs &&
                       ((ea & msk) == (e[31:0] & msk));
            end
            if (take) mdl[s][47] = 1'b0;
        end
    endfunction

    // Monitor: pops expected events and compares kind and latency
    always @(negedge clk) begin : mon
        int kind;
        exp_t e;
        if (!rst) begin
            if (done || err_illegal || err_priv) begin
                kind = done ? 0 : (err_illegal ? 1 : 2);
                if (sbq.size() == 0)
                    check(0, "R4", "unexpected event", 64'(kind), 64'hff);
                else begin
                    e = sbq.pop_front();
                    check(kind == e.kind, e.req, "event kind", 64'(kind), 64'(e.kind));
                    check(cyc - e.at == e.lat, "R12", "event latency", 64'(cyc - e.at), 64'(e.lat));
                end
            end
            if (prev_done || shadow_flush)
                check(shadow_flush == prev_done, "R12", "flush after done",
                      64'(shadow_flush), 64'(prev_done));
            prev_done = done;
        end
    end

    // Driver: issues a command and pushes the expected outcome
    task automatic issue(logic [1:0] mode, bit user, logic [31:0] ea, logic [7:0] pid,
                         bit ind, bit gs, string req);
        exp_t e;
        @(negedge clk);
        cmd_mode = mode; cmd_user = user; cmd_ea = ea; cmd_pid = pid;
        cmd_ind = ind; cmd_gs = gs; cmd_valid = 1;
        e.at = cyc; e.req = req;
        if (user) begin e.kind = 2; e.lat = 1; end
        else if (mode == 2'd2) begin e.kind = 1; e.lat = 1; end
        else begin
            e.kind = 0;
            e.lat = ((mode == 2'd3) ? N_ARR * WAYS : TOTAL) + 1;
            model_apply(mode, ea, pid, ind, gs);
        end
        sbq.push_back(e);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(int sel, logic [47:0] d);
        @(negedge clk);
        ent_wr_en = 1; ent_wr_sel = 5'(sel); ent_wr_data = d;
        @(negedge clk);
        ent_wr_en = 0;
        if (exists(sel)) mdl[sel] = d;
    endtask

    task automatic check_all(string req);
        for (int s = 0; s < TOTAL; s++) begin
            @(negedge clk);
            ent_rd_sel = 5'(s);
            #1;
            check(ent_rd_data == mdl[s], exists(s) ? req : "R3",
                  $sformatf("slot %0d", s), 64'(ent_rd_data), 64'(mdl[s]));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < TOTAL; s++) mdl[s] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R1: idle outputs and empty entries
        check({busy, done, err_illegal, err_priv, shadow_flush} == 5'b0, "R1",
              "outputs after reset", 64'({busy, done, err_illegal, err_priv, shadow_flush}), 0);
        check_all("R1");

        // R2/R3: background load, including the missing slots 28..31
        for (int s = 0; s < TOTAL; s++)
            wr(s, mk(1, (s % 5) == 4, 0, 0, 8'(s % 4), 4'(s % 3), 32'h1000_0000 + 32'(s << 12)));
        wr(6,  mk(1, 0, 0, 0, 8'd5, 4'd0, 32'h4000_3100));
        wr(7,  mk(1, 0, 1, 0, 8'd5, 4'd2, 32'h4000_3000));
        wr(22, mk(1, 0, 0, 0, 8'd5, 4'd4, 32'h4000_0000));
        wr(23, mk(1, 1, 0, 0, 8'd5, 4'd0, 32'h4000_3100));
        wr(8,  mk(1, 0, 0, 0, 8'd5, 4'd4, 32'h4000_0000));
        wr(13, mk(1, 0, 0, 1, 8'd7, 4'd1, 32'h4000_6000));
        check_all("R2");

        // R5: user mode is refused, even with the reserved code
        issue(2'd0, 1, 0, 0, 0, 0, "R5");
        wait_idle(); check_all("R5");
        issue(2'd2, 1, 0, 0, 0, 0, "R5");
        wait_idle();
        // R6: reserved scope code
        issue(2'd2, 0, 0, 0, 0, 0, "R6");
        wait_idle(); check_all("R6");

        // R9: page scope, slots 6 and 22 hit; 7 (indirect), 23 (protected), 8 (other set) stay
        issue(2'd3, 0, 32'h4000_3100, 8'd5, 0, 0, "R9");
        wait_idle(); check_all("R9");
        issue(2'd3, 0, 32'h4000_3100, 8'd5, 1, 0, "R9");
        wait_idle(); check_all("R9");
        // R10: set 6 lives only in array 0 (R3 hole in array 1)
        issue(2'd3, 0, 32'h4000_6000, 8'd7, 0, 1, "R10");
        wait_idle(); check_all("R10");

        // R8 with R4: write and command during the walk are ignored
        issue(2'd1, 0, 0, 8'd2, 0, 0, "R8");
        check(busy == 1'b1, "R12", "busy during walk", 64'(busy), 1);
        ent_wr_en = 1; ent_wr_sel = 5'd0; ent_wr_data = 48'hffff_ffff_ffff;
        cmd_mode = 2'd2; cmd_user = 0; cmd_valid = 1;
        @(negedge clk);
        ent_wr_en = 0; cmd_valid = 0;
        wait_idle(); check_all("R4");

        // R7: clear all; R11 protected entries survive
        issue(2'd0, 0, 0, 0, 0, 0, "R7");
        wait_idle(); check_all("R7");
        for (int s = 0; s < TOTAL; s++) begin
            if (exists(s) && mdl[s][46]) begin
                @(negedge clk);
                ent_rd_sel = 5'(s);
                #1;
                check(ent_rd_data[47] == 1'b1, "R11", $sformatf("protected slot %0d", s),
                      64'(ent_rd_data[47]), 1);
            end
        end

        check(sbq.size() == 0, "R12", "pending events", 64'(sbq.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule